// File: doc/BRIEF.md
# Wake-up pin driver controller

This block is the digital side of a high-side wake-up output pin. Software sets a small group of configuration bits. The block turns them into a driver enable for the analog high-side switch, a single-cycle interrupt pulse, and a few status bits. The output request reaches the driver through a fixed transport latency. A maximum-on-time monoflop limits how long the driver can stay on. A glitch filter sits on the short-circuit comparator, and a thermal event locks the driver off until software explicitly re-arms it.

The same pin can be turned into an input. The driver is then held off and every transition on the synchronised pin level raises an interrupt. The synchronised pin level is always visible as a status bit. All durations are parameters counted in clock cycles: `LAT_CYC` is the transport latency, `MONO_CYC` the maximum on-time, `SC_FILT_CYC` the short-circuit persistence and `SYNC_STG` the synchroniser depth. The reset is synchronous and active high.

Top module: `wake_drv_ctrl`

## Requirements
- R1: While `rst` is high and at the first clock after it, `drv_en`, `irq`, `sc_flag`, `therm_flag` and `pin_state` are all 0.
- R2: In output mode, with the monoflop off and no thermal lockout, `drv_en` copies `out_req` delayed by exactly `LAT_CYC`+1 clock edges, on both edges. An `out_req` pulse of w cycles gives a `drv_en` pulse of exactly w cycles.
- R3: With the monoflop on (`mono_off`=0), `drv_en` stays high for exactly `MONO_CYC` cycles after the delayed request rises, then goes low while the request stays high. The timer restarts from zero only after the delayed request has been low for at least one cycle and rises again.
- R4: With `mono_off`=1, `drv_en` stays high for as long as the delayed request is high, with no time limit.
- R5: When `sc_sense` is high for `SC_FILT_CYC` consecutive cycles, `sc_flag` is set and exactly one `irq` pulse is issued for that high run. A run of `SC_FILT_CYC`-1 cycles or fewer changes neither `sc_flag` nor `irq`.
- R6: `sc_flag` stays set until a pulse on `sc_clr`. The clear takes effect only in a cycle where `sc_sense` is low; while `sc_sense` is high the clear is ignored.
- R7: A `therm_hit` cycle drives `drv_en` low at the next edge and sets `therm_flag`. The driver stays locked off after `therm_hit` ends, until a `therm_rearm` pulse arrives in a cycle with `therm_hit` low. A rearm in the same cycle as `therm_hit` is ignored. `therm_clr` clears `therm_flag` only when `therm_hit` is low.
- R8: With `io_mode`=1, `drv_en` is 0 from the next edge on, whatever `out_req` and the monoflop do.
- R9: With `io_mode`=1, each transition of `pin_lvl` gives one `irq` pulse of one cycle, `SYNC_STG`+1 edges after the change. Transitions in output mode give no `irq`. A pin interrupt and a short-circuit interrupt that fall in the same cycle give a single pulse.
- R10: `pin_state` equals `pin_lvl` delayed by `SYNC_STG` edges (2 by default) in both modes. One edge after a change it still shows the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_req | input | 1 | Output-control configuration bit (1 = drive the pin high) |
| mono_off | input | 1 | 1 = maximum-on-time monoflop disabled |
| io_mode | input | 1 | 1 = pin used as input with edge interrupts |
| therm_rearm | input | 1 | Write pulse that re-enables the driver after a thermal lockout |
| sc_clr | input | 1 | Write-one-to-clear pulse for `sc_flag` |
| therm_clr | input | 1 | Write-one-to-clear pulse for `therm_flag` |
| sc_sense | input | 1 | Short-circuit comparator output, high = overcurrent |
| therm_hit | input | 1 | Thermal shutdown event, high while active |
| pin_lvl | input | 1 | Sampled logic level of the external pin (asynchronous) |
| drv_en | output | 1 | High-side driver enable |
| irq | output | 1 | Single-cycle interrupt pulse |
| sc_flag | output | 1 | Sticky short-circuit status |
| therm_flag | output | 1 | Sticky thermal-event status |
| pin_state | output | 1 | Synchronised pin level |

## Verification
The two interrupt sources share one output, so the bench lines up a short-circuit trip with a pin edge in input mode. The comparator is raised at a chosen cycle, and the pin is toggled `SC_FILT_CYC`-3 cycles later, so that both requests land on the same clock edge. The check expects one `irq` pulse, not two, with `sc_flag` set to show where the short-circuit part came from. A second coincidence puts a thermal event and a re-arm write in the same cycle, and the check expects the driver to stay locked off afterwards.

// File: rtl/wake_drv_pkg.sv
package wake_drv_pkg;

    // Monoflop phase for the maximum-on-time limiter
    typedef enum logic [1:0] {
        MF_IDLE    = 2'd0,
        MF_RUN     = 2'd1,
        MF_EXPIRED = 2'd2
    } mono_state_e;

    // Software configuration as seen inside the block
    typedef struct packed {
        logic out_req;
        logic mono_off;
        logic io_mode;
    } wake_cfg_t;

    // Sticky fault status
    typedef struct packed {
        logic sc;
        logic therm;
    } wake_stat_t;

    // Counter width able to hold the value n
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wake_req_delay.sv
module wake_req_delay #(
    parameter int LAT = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic tap [0:LAT];

    assign tap[0] = d;

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) tap[g+1] <= 1'b0;
            else     tap[g+1] <= tap[g];
        end
    end

    assign q = tap[LAT];
endmodule

// File: rtl/wake_monoflop.sv
module wake_monoflop
    import wake_drv_pkg::*;
#(
    parameter int MONO = 1300000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic req,
    output logic allow
);
    localparam int CW = cnt_bits(MONO);
    localparam logic [CW-1:0] LIM = CW'(MONO);

    mono_state_e     state;
    logic [CW-1:0]   cnt;
    logic [CW-1:0]   cnt_nxt;

    assign cnt_nxt = cnt + CW'(1);

    always_ff @(posedge clk) begin
        if (rst || hold || !req) begin
            state <= MF_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                MF_IDLE, MF_RUN: begin
                    cnt   <= cnt_nxt;
                    state <= (cnt_nxt == LIM) ? MF_EXPIRED : MF_RUN;
                end
                default: begin
                    cnt   <= cnt;
                    state <= MF_EXPIRED;
                end
            endcase
        end
    end

    assign allow = (state != MF_EXPIRED);
endmodule

// File: rtl/wake_sc_filter.sv
module wake_sc_filter
    import wake_drv_pkg::*;
#(
    parameter int SC = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic sense,
    output logic trip
);
    localparam int CW = cnt_bits(SC);
    localparam logic [CW-1:0] LIM  = CW'(SC);
    localparam logic [CW-1:0] LAST = CW'(SC - 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst || !sense) run <= '0;
        else if (run != LIM) run <= run + CW'(1);
    end

    // fires once, in the SC-th consecutive high cycle
    assign trip = sense && (run == LAST);
endmodule

// File: rtl/wake_pin_sync.sv
module wake_pin_sync #(
    parameter int STG = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic toggled
);
    logic [STG:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STG-1:0], pin};
    end

    assign level   = sh[STG-1];
    assign toggled = sh[STG-1] ^ sh[STG];
endmodule

// File: rtl/wake_drv_ctrl.sv
module wake_drv_ctrl
    import wake_drv_pkg::*;
#(
    parameter int LAT_CYC     = 10,
    parameter int MONO_CYC    = 1300000,
    parameter int SC_FILT_CYC = 400,
    parameter int SYNC_STG    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic out_req,
    input  logic mono_off,
    input  logic io_mode,
    input  logic therm_rearm,
    input  logic sc_clr,
    input  logic therm_clr,
    input  logic sc_sense,
    input  logic therm_hit,
    input  logic pin_lvl,
    output logic drv_en,
    output logic irq,
    output logic sc_flag,
    output logic therm_flag,
    output logic pin_state
);
    wake_cfg_t  cfg;
    wake_stat_t stat_q;
    logic       req_dly;
    logic       mono_ok;
    logic       sc_trip;
    logic       pin_tgl;
    logic       lock_q;
    logic       drv_q;
    logic       irq_q;
    logic       drv_nxt;

    assign cfg.out_req  = out_req;
    assign cfg.mono_off = mono_off;
    assign cfg.io_mode  = io_mode;

    wake_req_delay #(.LAT(LAT_CYC)) i_dly (
        .clk (clk),
        .rst (rst),
        .d   (cfg.out_req),
        .q   (req_dly)
    );

    wake_monoflop #(.MONO(MONO_CYC)) i_mono (
        .clk   (clk),
        .rst   (rst),
        .hold  (cfg.io_mode),
        .req   (req_dly),
        .allow (mono_ok)
    );

    wake_sc_filter #(.SC(SC_FILT_CYC)) i_scf (
        .clk   (clk),
        .rst   (rst),
        .sense (sc_sense),
        .trip  (sc_trip)
    );

    wake_pin_sync #(.STG(SYNC_STG)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .pin     (pin_lvl),
        .level   (pin_state),
        .toggled (pin_tgl)
    );

    assign drv_nxt = !cfg.io_mode && !lock_q && !therm_hit && req_dly
                     && (cfg.mono_off || mono_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            stat_q <= '0;
            drv_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (therm_hit)        lock_q <= 1'b1;
            else if (therm_rearm) lock_q <= 1'b0;

            if (therm_hit)        stat_q.therm <= 1'b1;
            else if (therm_clr)   stat_q.therm <= 1'b0;

            if (sc_trip)                   stat_q.sc <= 1'b1;
            else if (sc_clr && !sc_sense)  stat_q.sc <= 1'b0;

            drv_q <= drv_nxt;
            irq_q <= sc_trip || (cfg.io_mode && pin_tgl);
        end
    end

    assign drv_en     = drv_q;
    assign irq        = irq_q;
    assign sc_flag    = stat_q.sc;
    assign therm_flag = stat_q.therm;
endmodule

// File: rtl/wake_drv_ctrl_chk.sv
module wake_drv_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic io_mode,
    input logic sc_sense,
    input logic therm_hit,
    input logic pin_lvl,
    input logic drv_en,
    input logic irq,
    input logic sc_flag,
    input logic therm_flag,
    input logic pin_state
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R8: input mode never drives the pin
    p_io_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
        io_mode |=> !drv_en);

    // R7: a thermal event shuts the driver and flags it
    p_therm_off_r7: assert property (@(posedge clk) disable iff (rst)
        therm_hit |=> (!drv_en && therm_flag));

    // R6: the short flag survives any clear while the comparator is high
    p_sc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sc_flag && sc_sense) |=> sc_flag);

    // R5: a new short flag always comes with an interrupt
    p_sc_irq_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sc_flag) |-> irq);

    // R10: pin status is the pin delayed by the synchroniser
    p_pin_level_r10: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (pin_state == $past(pin_lvl, 2)));
endmodule

bind wake_drv_ctrl wake_drv_ctrl_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .io_mode    (io_mode),
    .sc_sense   (sc_sense),
    .therm_hit  (therm_hit),
    .pin_lvl    (pin_lvl),
    .drv_en     (drv_en),
    .irq        (irq),
    .sc_flag    (sc_flag),
    .therm_flag (therm_flag),
    .pin_state  (pin_state)
);

// File: tb/test_wake_drv_ctrl.sv
module test_wake_drv_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int LAT  = 4;
    localparam int MONO = 20;
    localparam int SC   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic out_req = 0, mono_off = 0, io_mode = 0, therm_rearm = 0;
    logic sc_clr = 0, therm_clr = 0, sc_sense = 0, therm_hit = 0, pin_lvl = 0;
    logic drv_en, irq, sc_flag, therm_flag, pin_state;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wake_drv_ctrl #(
        .LAT_CYC(LAT), .MONO_CYC(MONO), .SC_FILT_CYC(SC), .SYNC_STG(2)
    ) i_wake_drv_ctrl (
        .clk(clk), .rst(rst), .out_req(out_req), .mono_off(mono_off),
        .io_mode(io_mode), .therm_rearm(therm_rearm), .sc_clr(sc_clr),
        .therm_clr(therm_clr), .sc_sense(sc_sense), .therm_hit(therm_hit),
        .pin_lvl(pin_lvl), .drv_en(drv_en), .irq(irq), .sc_flag(sc_flag),
        .therm_flag(therm_flag), .pin_state(pin_state)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int k, hi, lo, pulses;
        bit prev_irq, dbl;

        // ---------------- R1: reset state ----------------
        repeat (3) tick();
        chk({drv_en, irq, sc_flag, therm_flag, pin_state} == 5'b0,
            "R1 outputs in reset", {drv_en, irq, sc_flag, therm_flag, pin_state}, 0);
        rst = 1'b0;
        tick();
        chk({drv_en, irq, sc_flag, therm_flag, pin_state} == 5'b0,
            "R1 outputs after reset", {drv_en, irq, sc_flag, therm_flag, pin_state}, 0);

        // ---------------- R2: latency, rise and fall ----------------
        mono_off = 1'b1;
        out_req  = 1'b1;
        k = 0;
        for (int i = 1; i <= 60; i++) begin tick(); if (drv_en) begin k = i; break; end end
        chk(k == LAT + 1, "R2 rise latency", k, LAT + 1);
        out_req = 1'b0;
        k = 0;
        for (int i = 1; i <= 60; i++) begin tick(); if (!drv_en) begin k = i; break; end end
        chk(k == LAT + 1, "R2 fall latency", k, LAT + 1);
        repeat (LAT + 2) tick();

        // R2: pulse widths preserved
        for (int w = 1; w <= 4; w++) begin
            hi = 0;
            out_req = 1'b1;
            for (int i = 0; i < 2*LAT + w + 6; i++) begin
                if (i == w) out_req = 1'b0;
                tick();
                if (drv_en) hi++;
            end
            chk(hi == w, "R2 pulse width", hi, w);
        end

        // ---------------- R3: monoflop ----------------
        mono_off = 1'b0;
        out_req  = 1'b1;
        hi = 0;
        for (int i = 0; i < LAT + 1 + 3*MONO; i++) begin tick(); if (drv_en) hi++; end
        chk(hi == MONO, "R3 on-time", hi, MONO);
        chk(drv_en == 1'b0, "R3 stays off after timeout", drv_en, 0);
        for (int g = 1; g <= 3; g++) begin
            hi = 0;
            out_req = 1'b0;
            for (int i = 0; i < g; i++) begin tick(); if (drv_en) hi++; end
            out_req = 1'b1;
            for (int i = 0; i < LAT + 1 + 2*MONO; i++) begin tick(); if (drv_en) hi++; end
            chk(hi == MONO, "R3 relaunch after low gap", hi, MONO);
        end
        out_req = 1'b0;
        repeat (LAT + 3) tick();

        // ---------------- R4: monoflop disabled ----------------
        mono_off = 1'b1;
        out_req  = 1'b1;
        repeat (LAT + 2) tick();
        lo = 0;
        for (int i = 0; i < 3*MONO; i++) begin tick(); if (!drv_en) lo++; end
        chk(lo == 0, "R4 no time limit", lo, 0);

        // ---------------- R7: thermal lockout ----------------
        therm_hit = 1'b1;
        tick();
        chk(drv_en == 1'b0, "R7 thermal shuts driver", drv_en, 0);
        chk(therm_flag == 1'b1, "R7 thermal flag set", therm_flag, 1);
        therm_clr = 1'b1; tick(); therm_clr = 1'b0; tick();
        chk(therm_flag == 1'b1, "R7 clear ignored while event", therm_flag, 1);
        therm_rearm = 1'b1;
        tick();
        therm_hit = 1'b0; therm_rearm = 1'b0;
        hi = 0;
        for (int i = 0; i < 5; i++) begin tick(); if (drv_en) hi++; end
        chk(hi == 0, "R7 rearm during event ignored", hi, 0);
        therm_rearm = 1'b1; tick(); therm_rearm = 1'b0; tick();
        chk(drv_en == 1'b1, "R7 rearm restores driver", drv_en, 1);
        therm_clr = 1'b1; tick(); therm_clr = 1'b0; tick();
        chk(therm_flag == 1'b0, "R7 flag cleared", therm_flag, 0);

        // ---------------- R5/R6: short-circuit filter sweep ----------------
        for (int n = 1; n <= SC + 2; n++) begin
            pulses = 0;
            for (int i = 0; i < n; i++) begin sc_sense = 1'b1; tick(); if (irq) pulses++; end
            sc_sense = 1'b0;
            for (int i = 0; i < 3; i++) begin tick(); if (irq) pulses++; end
            chk(sc_flag == (n >= SC), "R5 flag vs run length", sc_flag, (n >= SC));
            chk(pulses == ((n >= SC) ? 1 : 0), "R5 irq count vs run length",
                pulses, (n >= SC) ? 1 : 0);
            sc_clr = 1'b1; tick(); sc_clr = 1'b0; tick();
            chk(sc_flag == 1'b0, "R6 clear with comparator low", sc_flag, 0);
        end
        sc_sense = 1'b1;
        repeat (SC + 2) tick();
        sc_clr = 1'b1; tick(); sc_clr = 1'b0; tick();
        chk(sc_flag == 1'b1, "R6 clear ignored while short", sc_flag, 1);
        sc_sense = 1'b0; tick();
        sc_clr = 1'b1; tick(); sc_clr = 1'b0; tick();
        chk(sc_flag == 1'b0, "R6 clear after short ends", sc_flag, 0);

        // ---------------- R8: input mode ----------------
        io_mode = 1'b1;   // out_req still high, monoflop off
        tick();
        hi = 0;
        for (int i = 0; i < 3*MONO; i++) begin tick(); if (drv_en) hi++; end
        chk(hi == 0, "R8 driver held off in input mode", hi, 0);

        // ---------------- R9/R10: pin edges ----------------
        for (int gap = 3; gap <= 6; gap++) begin
            pulses = 0; dbl = 0; prev_irq = 0;
            pin_lvl = ~pin_lvl;
            for (int i = 1; i <= gap; i++) begin
                tick();
                if (i == 1) chk(pin_state == !pin_lvl, "R10 old level after one edge",
                                pin_state, !pin_lvl);
                if (i == 2) chk(pin_state == pin_lvl, "R10 new level after two edges",
                                pin_state, pin_lvl);
                if (irq) pulses++;
                if (irq && prev_irq) dbl = 1;
                prev_irq = irq;
            end
            chk(pulses == 1 && !dbl, "R9 one single-cycle irq per edge", pulses, 1);
        end
        io_mode = 1'b0;
        tick();
        pulses = 0;
        for (int t = 0; t < 4; t++) begin
            pin_lvl = ~pin_lvl;
            for (int i = 0; i < 4; i++) begin tick(); if (irq) pulses++; end
        end
        chk(pulses == 0, "R9 no irq in output mode", pulses, 0);
        chk(pin_state == pin_lvl, "R10 level tracked in output mode", pin_state, pin_lvl);

        // ---------------- R9/R5: coincident sources ----------------
        io_mode = 1'b1;
        repeat (3) tick();
        pulses = 0;
        for (int i = 0; i <= SC + 4; i++) begin
            if (i == 0) sc_sense = 1'b1;
            if (i == SC - 3) pin_lvl = ~pin_lvl;
            if (i == SC) sc_sense = 1'b0;
            tick();
            if (irq) pulses++;
        end
        chk(pulses == 1, "R9 coincident irq merged", pulses, 1);
        chk(sc_flag == 1'b1, "R5 short flagged on coincidence", sc_flag, 1);

        done = 1;
        finish_run();
    end
endmodule